// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one address request into the ordered series of single-byte address cycles that a NAND flash device expects. A request is taken on a one-cycle start strobe. In phase mode it has an optional column phase and an optional page phase. In byte-offset mode it is a single 32-bit flash byte offset. The page size (512 or 2048 bytes) and the log2 of the device size in bytes set how many bytes are sent and which address bits each byte carries. Column bytes are always zero, because every transfer covers a whole page.

The bytes go to the downstream operation engine as a ready/valid stream, one byte per accepted handshake. When the last byte has been accepted, the block pulses `done`. A request with no phases sends no bytes and completes at once. Inputs are sampled only on the accepted start strobe, so the requester may change them while a sequence runs.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, `cyc_valid`, `done` and `busy` are all low.
- R2: In phase mode with `col_en`=1, the sequence begins with one zero byte when `large_page`=0 and with two zero bytes when `large_page`=1.
- R3: In phase mode with `page_en`=1, the page phase sends `page_addr[7:0]` first and then `page_addr[15:8]`.
- R4: With `large_page`=1, a third page byte `page_addr[23:16]` follows only when `size_log2` >= 28 (256 MiB or more).
- R5: With `large_page`=0, a third page byte `page_addr[23:16]` follows only when `size_log2` >= 26 (64 MiB or more).
- R6: A phase whose enable is 0 sends no bytes. With both enables at 0 in phase mode, no byte is presented, and `done` is high in the cycle after the start strobe.
- R7: In byte-offset mode (`off_mode`=1) with `large_page`=1, the bytes are offset[7:0], offset[7:0], offset[18:11], offset[26:19] and {3'b000, offset[31:27]}. The enables are ignored.
- R8: In byte-offset mode with `large_page`=0, the bytes are offset[7:0], offset[16:9], offset[24:17] and {1'b0, offset[31:25]}.
- R9: Once `cyc_valid` is high, it stays high and `cyc_byte` stays unchanged until the cycle in which `cyc_ready` is high. The first byte is presented in the cycle after the start strobe.
- R10: `done` is high for exactly one cycle, in the cycle after the final byte is accepted. `busy` is high from the cycle after the start strobe through the `done` cycle.
- R11: A start strobe seen while `busy` is high is ignored. The sequence in progress and its bytes are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| off_mode | input | 1 | 1: byte-offset mode, 0: phase mode |
| col_en | input | 1 | Column phase present (phase mode) |
| page_en | input | 1 | Page phase present (phase mode) |
| large_page | input | 1 | 1: 2048-byte pages, 0: 512-byte pages |
| size_log2 | input | 6 | log2 of device size in bytes |
| page_addr | input | 24 | Page number (phase mode) |
| byte_off | input | 32 | Flash byte offset (byte-offset mode) |
| cyc_valid | output | 1 | Address byte presented |
| cyc_byte | output | 8 | Address byte value |
| cyc_ready | input | 1 | Engine accepts the presented byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The bench probes `size_log2` on each side of both density thresholds, 25/26 for small pages and 27/28 for large pages. A wrong comparison shows up as a missing or extra third page byte. It issues a request with no phases, where a design that enters the sending state would present a stray byte or never finish. Stalls from a pseudo-random ready pattern check that a byte is neither skipped nor replaced while it waits. A second start strobe with different inputs is sent in the middle of a sequence, and a design that reloads on it would emit the wrong bytes or restart its count.

// File: rtl/nas_pkg.sv
package nas_pkg;
  localparam int BYTE_W  = 8;
  localparam int CYC_MAX = 5;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);
  localparam int OFF_W   = 32;
  localparam int PAGE_W  = 3 * BYTE_W;

  typedef logic [BYTE_W-1:0] cyc_byte_t;
  typedef cyc_byte_t [CYC_MAX-1:0] cyc_list_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_FIN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/nas_planner.sv
module nas_planner
  import nas_pkg::*;
#(
  parameter int SIZE_W    = 6,
  parameter int LG_THRESH = 28,
  parameter int SM_THRESH = 26
) (
  input  logic              off_mode,
  input  logic              col_en,
  input  logic              page_en,
  input  logic              large_page,
  input  logic [SIZE_W-1:0] size_log2,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [OFF_W-1:0]  byte_off,
  output cyc_list_t         list,
  output logic [CNT_W-1:0]  cnt
);
  logic wide_dev;
  assign wide_dev = large_page ? (int'(size_log2) >= LG_THRESH)
                               : (int'(size_log2) >= SM_THRESH);

  always_comb begin
    logic [CNT_W-1:0] n;
    list = '0;
    n    = '0;
    if (off_mode) begin
      list[0] = byte_off[7:0];
      if (large_page) begin
        list[1] = byte_off[7:0];
        list[2] = byte_off[18:11];
        list[3] = byte_off[26:19];
        list[4] = {3'b000, byte_off[31:27]};
        n = CNT_W'(5);
      end else begin
        list[1] = byte_off[16:9];
        list[2] = byte_off[24:17];
        list[3] = {1'b0, byte_off[31:25]};
        n = CNT_W'(4);
      end
    end else begin
      if (col_en) begin
        list[n] = '0;
        n = n + CNT_W'(1);
        if (large_page) begin
          list[n] = '0;
          n = n + CNT_W'(1);
        end
      end
      if (page_en) begin
        list[n] = page_addr[BYTE_W-1:0];
        n = n + CNT_W'(1);
        list[n] = page_addr[2*BYTE_W-1:BYTE_W];
        n = n + CNT_W'(1);
        if (wide_dev) begin
          list[n] = page_addr[3*BYTE_W-1:2*BYTE_W];
          n = n + CNT_W'(1);
        end
      end
    end
    cnt = n;
  end

  // R2: a column-only request carries one or two bytes by page size
  always_comb begin
    if (!off_mode && col_en && !page_en)
      p_col_len_r2: assert (cnt == (large_page ? CNT_W'(2) : CNT_W'(1)));
  end
endmodule

// File: rtl/nas_queue.sv
module nas_queue
  import nas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic             busy,
  input  cyc_list_t        list_in,
  input  logic [CNT_W-1:0] cnt_in,
  output cyc_byte_t        cur_byte,
  output logic             last,
  output logic             empty_in
);
  cyc_list_t        buf_q, buf_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             en;

  assign en = load | adv;

  always_comb begin
    buf_d   = buf_q;
    total_d = total_q;
    idx_d   = idx_q;
    if (load) begin
      buf_d   = list_in;
      total_d = cnt_in;
      idx_d   = '0;
    end else if (adv) begin
      idx_d = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      total_q <= '0;
      idx_q   <= '0;
    end else if (en) begin
      buf_q   <= buf_d;
      total_q <= total_d;
      idx_q   <= idx_d;
    end
  end

  assign cur_byte = (int'(idx_q) < CYC_MAX) ? buf_q[idx_q] : '0;
  assign last     = (idx_q + CNT_W'(1)) == total_q;
  assign empty_in = (cnt_in == '0);

  // R11: the loaded request does not change while a sequence runs
  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> $stable(total_q) && $stable(buf_q));

  // R9: stepping never runs past the loaded length
  p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (idx_q < total_q));
endmodule

// File: rtl/nas_ctrl.sv
module nas_ctrl
  import nas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic empty_in,
  input  logic last,
  input  logic ready,
  output logic load,
  output logic adv,
  output logic valid,
  output logic done,
  output logic busy
);
  seq_st_e st_q, st_d;
  logic    accept;

  assign valid  = (st_q == ST_SEND);
  assign accept = valid & ready;
  assign load   = (st_q == ST_IDLE) & start;
  assign adv    = accept;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = empty_in ? ST_FIN : ST_SEND;
      ST_SEND: if (accept && last) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign done = (st_q == ST_FIN);
  assign busy = (st_q != ST_IDLE);

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: completion follows a final accept or an empty request
  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(accept && last) || $past(load && empty_in));

  // R6: an empty request never presents a byte
  p_empty_nobyte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && empty_in) |=> !valid);
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nas_pkg::*;
#(
  parameter int SIZE_W    = 6,
  parameter int LG_THRESH = 28,
  parameter int SM_THRESH = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              off_mode,
  input  logic              col_en,
  input  logic              page_en,
  input  logic              large_page,
  input  logic [SIZE_W-1:0] size_log2,
  input  logic [23:0]       page_addr,
  input  logic [31:0]       byte_off,
  output logic              cyc_valid,
  output logic [7:0]        cyc_byte,
  input  logic              cyc_ready,
  output logic              done,
  output logic              busy
);
  cyc_list_t        list;
  logic [CNT_W-1:0] cnt;
  logic             load, adv, last, empty_in;

  nas_planner #(
    .SIZE_W(SIZE_W), .LG_THRESH(LG_THRESH), .SM_THRESH(SM_THRESH)
  ) u_plan (
    .off_mode(off_mode), .col_en(col_en), .page_en(page_en),
    .large_page(large_page), .size_log2(size_log2),
    .page_addr(page_addr), .byte_off(byte_off),
    .list(list), .cnt(cnt)
  );

  nas_queue u_queue (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .busy(busy),
    .list_in(list), .cnt_in(cnt),
    .cur_byte(cyc_byte), .last(last), .empty_in(empty_in)
  );

  nas_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .empty_in(empty_in),
    .last(last), .ready(cyc_ready), .load(load), .adv(adv),
    .valid(cyc_valid), .done(done), .busy(busy)
  );

  // R9: a stalled byte stays presented and unchanged
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=> cyc_valid && $stable(cyc_byte));

  // R10: busy covers the whole sequence up to the completion pulse
  p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid || done) |-> busy);
endmodule

// File: tb/tb_nand_addr_seq.sv
module tb_nand_addr_seq;
  localparam int CLK_PERIOD = 10;
  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, off_mode, col_en, page_en, large_page, cyc_ready;
  logic [5:0]  size_log2;
  logic [23:0] page_addr;
  logic [31:0] byte_off;
  logic        cyc_valid, done, busy;
  logic [7:0]  cyc_byte;

  int vec_n = 0;
  int err_n = 0;
  int cyc_n = 0;
  string cur_req = "R1";

  bq_t m_q;
  int  m_ph = 0;
  int  rdy_mode = 0;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .off_mode(off_mode),
    .col_en(col_en), .page_en(page_en), .large_page(large_page),
    .size_log2(size_log2), .page_addr(page_addr), .byte_off(byte_off),
    .cyc_valid(cyc_valid), .cyc_byte(cyc_byte), .cyc_ready(cyc_ready),
    .done(done), .busy(busy)
  );

  function automatic bq_t mk_list();
    bq_t q;
    q = {};
    if (off_mode) begin
      if (large_page) begin
        q.push_back(byte_off[7:0]);
        q.push_back(byte_off[7:0]);
        q.push_back(byte_off[18:11]);
        q.push_back(byte_off[26:19]);
        q.push_back({3'b000, byte_off[31:27]});
      end else begin
        q.push_back(byte_off[7:0]);
        q.push_back(byte_off[16:9]);
        q.push_back(byte_off[24:17]);
        q.push_back({1'b0, byte_off[31:25]});
      end
    end else begin
      if (col_en) begin
        q.push_back(8'h00);
        if (large_page) q.push_back(8'h00);
      end
      if (page_en) begin
        q.push_back(page_addr[7:0]);
        q.push_back(page_addr[15:8]);
        if ((large_page && size_log2 >= 28) || (!large_page && size_log2 >= 26))
          q.push_back(page_addr[23:16]);
      end
    end
    return q;
  endfunction

  task automatic model_update();
    if (m_ph == 0) begin
      if (start) begin
        m_q  = mk_list();
        m_ph = (m_q.size() == 0) ? 2 : 1;
      end
    end else if (m_ph == 1) begin
      if (cyc_ready) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_ph = 2;
      end
    end else begin
      m_ph = 0;
    end
  endtask

  task automatic compare();
    logic ev, ed, eb;
    logic [7:0] ebyte;
    ev = (m_ph == 1);
    ed = (m_ph == 2);
    eb = (m_ph != 0);
    ebyte = ev ? m_q[0] : 8'h00;
    vec_n++;
    if (cyc_valid !== ev || done !== ed || busy !== eb ||
        (ev && cyc_byte !== ebyte)) begin
      err_n++;
      $display("FAIL %s: valid/done/busy/byte = %b/%b/%b/%02h expected %b/%b/%b/%02h",
               cur_req, cyc_valid, done, busy, cyc_byte, ev, ed, eb, ebyte);
    end
  endtask

  task automatic step();
    @(negedge clk);
    model_update();
    compare();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    cyc_ready = (rdy_mode == 0) ? 1'b1 : lf[0];
  endtask

  task automatic run_req(string req, logic om, logic ce, logic pe, logic lp,
                         logic [5:0] sz, logic [23:0] pa, logic [31:0] bo, int rm);
    cur_req = req;
    rdy_mode = rm;
    off_mode = om; col_en = ce; page_en = pe; large_page = lp;
    size_log2 = sz; page_addr = pa; byte_off = bo;
    start = 1'b1;
    step();
    start = 1'b0;
    for (int k = 0; k < 80 && m_ph != 0; k++) step();
    step();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; off_mode = 1'b0; col_en = 1'b0;
    page_en = 1'b0; large_page = 1'b0; size_log2 = '0; page_addr = '0;
    byte_off = '0; cyc_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs after reset
    cur_req = "R1";
    repeat (2) step();

    // R2: column phase length
    run_req("R2", 0, 1, 0, 0, 6'd30, 24'h123456, 0, 0);
    run_req("R2", 0, 1, 0, 1, 6'd30, 24'h123456, 0, 0);
    // R3 / R5: small page thresholds
    run_req("R5", 0, 0, 1, 0, 6'd25, 24'hA1B2C3, 0, 0);
    run_req("R5", 0, 0, 1, 0, 6'd26, 24'hA1B2C3, 0, 0);
    run_req("R3", 0, 1, 1, 0, 6'd24, 24'h00F00D, 0, 1);
    // R4: large page thresholds
    run_req("R4", 0, 0, 1, 1, 6'd27, 24'h5A6B7C, 0, 0);
    run_req("R4", 0, 0, 1, 1, 6'd28, 24'h5A6B7C, 0, 0);
    run_req("R4", 0, 1, 1, 1, 6'd31, 24'hFEDCBA, 0, 1);
    // R6: nothing requested
    run_req("R6", 0, 0, 0, 1, 6'd31, 24'hFFFFFF, 0, 0);
    // R7 / R8: byte-offset mode, enables ignored
    run_req("R7", 1, 0, 0, 1, 6'd20, 24'h0, 32'hDEADBEEF, 0);
    run_req("R7", 1, 1, 1, 1, 6'd20, 24'h0, 32'h87654321, 1);
    run_req("R8", 1, 0, 0, 0, 6'd20, 24'h0, 32'hCAFEF00D, 0);
    run_req("R8", 1, 1, 0, 0, 6'd20, 24'h0, 32'h13579BDF, 1);
    // R9: heavy stalling
    run_req("R9", 0, 1, 1, 1, 6'd29, 24'h3C4D5E, 0, 1);

    // R11: second strobe with different inputs mid-sequence
    cur_req = "R11";
    rdy_mode = 0;
    cyc_ready = 1'b0;
    off_mode = 0; col_en = 0; page_en = 1; large_page = 0;
    size_log2 = 6'd27; page_addr = 24'h112233; byte_off = '0;
    start = 1'b1;
    step();
    start = 1'b0;
    cyc_ready = 1'b0;
    step();
    cyc_ready = 1'b0;
    off_mode = 1; byte_off = 32'hFFFF_FFFF; col_en = 1; large_page = 1;
    start = 1'b1;
    step();
    start = 1'b0;
    cyc_ready = 1'b1;
    for (int k = 0; k < 20 && m_ph != 0; k++) step();
    step();
    start = 1'b1;
    step();
    start = 1'b0;
    for (int k = 0; k < 20 && m_ph != 0; k++) step();
    repeat (2) step();

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
    $finish;
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 20000) begin
      err_n++;
      $display("FAIL watchdog: cycles %0d expected below 20000", cyc_n);
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
      $finish;
    end
  end
endmodule